// File: doc/BRIEF.md
# Sampled Consecutive-Agreement Glitch Filter

This block cleans one logic signal in the bus clock domain. The input is registered, then looked at once every `PERIOD` bus clocks. The filtered output moves to a new level only after a programmed number of back-to-back samples have all shown that level. A short pulse or dip that ends before enough samples have agreed is dropped, so the output never sees it.

Two configuration inputs control the filter. An 8-bit sample period sets how many bus clocks pass between samples. A 3-bit count code sets how many samples must agree. A period of zero turns the filter off and the input drives the output directly. Whenever either configuration value changes, any transition that was in progress is discarded and counting starts again under the new settings.

Top module: `glitch_filter`

## Requirements
- R1: The count code `cnt_code_i` (0 to 7) selects N = code + 3 required agreeing samples, so code 0 needs 3 samples and code 7 needs 10.
- R2: When `period_i` is between 1 and 255, a sample is taken every `period_i` bus clocks while the input differs from the filtered level.
- R3: When `period_i` is 0 the filter is bypassed and `sig_out` equals `sig_in` in the same cycle, with no register in the path.
- R4: With the filter enabled, a level change on `sig_in` that is held long enough appears on `sig_out` exactly N × `period_i` + 2 bus clock edges after the change. This holds for both rising and falling changes.
- R5: An excursion of `sig_in` away from the output level that lasts fewer than N × `period_i` cycles never reaches `sig_out`. This applies to both polarities.
- R6: If the registered input returns to the current output level, even for a single cycle, all agreement progress is cleared. A later change then needs the full N × `period_i` + 2 cycles.
- R7: After reset `sig_out` is 0.
- R8: A change of `period_i` or `cnt_code_i` discards any pending progress. A held input change is then reported N × `period_i` + 2 edges after the configuration change, using the new values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sig_in | input | 1 | Signal to be filtered, already synchronous to `clk` |
| period_i | input | 8 | Bus clocks between samples; 0 selects bypass |
| cnt_code_i | input | 3 | Agreement count code; N = code + 3 |
| sig_out | output | 1 | Filtered signal |

## Verification
The bench times edge-to-edge latency for several count and period pairs, including the largest setting. A design with an off-by-one in the prescaler or the agreement counter would miss the N × period + 2 figure by a period or by a single cycle. Pulses and dips just shorter than the window are applied to show they are rejected; a counter that kept progress across a brief return to the old level would let a chopped pulse through early. The bench also changes the period partway through a pending transition. A design that keeps the old schedule would switch about seventeen cycles too soon. Finally, bypass is checked within the same cycle, which catches any register left in the bypass path.

// File: rtl/gf_pkg.sv
package gf_pkg;
    localparam int PER_W    = 8;
    localparam int CNT_W    = 3;
    localparam int CNT_BASE = 3;
    localparam int AGR_W    = $clog2((1 << CNT_W) + CNT_BASE);

    typedef struct packed {
        logic             in;
        logic             filt;
        logic             out;
        logic [PER_W-1:0] per;
        logic [CNT_W-1:0] code;
    } gf_state_t;
endpackage

// File: rtl/gf_prescale.sv
module gf_prescale #(
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [PER_W-1:0] period,
    output logic             tick
);
    logic [PER_W-1:0] presc_d, presc_q;

    always_comb begin
        presc_d = presc_q;
        tick    = 1'b0;
        if (clear) begin
            presc_d = '0;
        end else if (presc_q == period - PER_W'(1)) begin
            presc_d = '0;
            tick    = 1'b1;
        end else begin
            presc_d = presc_q + PER_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) presc_q <= '0;
        else        presc_q <= presc_d;
    end

    // R2: the prescaler never runs past the programmed period once it is stable
    assert_presc_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(period) && period != '0) |-> (presc_q < period));
endmodule

// File: rtl/gf_agree.sv
module gf_agree #(
    parameter int AGR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic [AGR_W-1:0] need,
    output logic             done
);
    logic [AGR_W-1:0] agree_d, agree_q;

    always_comb begin
        agree_d = agree_q;
        done    = 1'b0;
        if (clear) begin
            agree_d = '0;
        end else if (tick) begin
            if (agree_q == need - AGR_W'(1)) begin
                done    = 1'b1;
                agree_d = '0;
            end else begin
                agree_d = agree_q + AGR_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) agree_q <= '0;
        else        agree_q <= agree_d;
    end

    // R1: progress stays below the required sample count
    assert_agree_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(need) && need != '0) |-> (agree_q < need));
endmodule

// File: rtl/glitch_filter.sv
module glitch_filter
    import gf_pkg::*;
#(
    parameter int P_W    = PER_W,
    parameter int C_W    = CNT_W,
    parameter int C_BASE = CNT_BASE
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sig_in,
    input  logic [P_W-1:0] period_i,
    input  logic [C_W-1:0] cnt_code_i,
    output logic           sig_out
);
    localparam int A_W = $clog2((1 << C_W) + C_BASE);

    typedef struct packed {
        logic           in;
        logic           filt;
        logic           out;
        logic [P_W-1:0] per;
        logic [C_W-1:0] code;
    } st_t;

    st_t st_d, st_q;

    logic           bypass;
    logic           cfg_chg;
    logic           clr;
    logic           tick;
    logic           done;
    logic [A_W-1:0] need;

    assign bypass  = (period_i == '0);
    assign cfg_chg = (period_i != st_q.per) || (cnt_code_i != st_q.code);
    assign clr     = bypass || cfg_chg || (st_q.in == st_q.filt);
    assign need    = A_W'(cnt_code_i) + A_W'(C_BASE);

    gf_prescale #(.PER_W(P_W)) i_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (clr),
        .period (period_i),
        .tick   (tick)
    );

    gf_agree #(.AGR_W(A_W)) i_agree (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (clr),
        .tick   (tick),
        .need   (need),
        .done   (done)
    );

    always_comb begin
        st_d      = st_q;
        st_d.in   = sig_in;
        st_d.per  = period_i;
        st_d.code = cnt_code_i;
        st_d.out  = st_q.filt;
        if (bypass)    st_d.filt = st_q.in;
        else if (done) st_d.filt = ~st_q.filt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sig_out = bypass ? sig_in : st_q.out;

    // R6: a sample tick only occurs while the input disagrees with the level
    assert_tick_disagree_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (st_q.in != st_q.filt));

    // R5: the filtered level only moves toward a differing registered input
    assert_move_toward_input_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.filt != $past(st_q.filt)) |-> ($past(st_q.in) != $past(st_q.filt)));

    // R8: no completion in a cycle where the configuration has just moved
    assert_no_done_on_cfg_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_chg |-> !done);
endmodule

// File: tb/test_glitch_filter.sv
`timescale 1ns/1ps
module test_glitch_filter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sig_in = 1'b0;
    logic [7:0] period_i = 8'd1;
    logic [2:0] cnt_code_i = 3'd0;
    logic       sig_out;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    glitch_filter i_glitch_filter (
        .clk        (clk),
        .rst_n      (rst_n),
        .sig_in     (sig_in),
        .period_i   (period_i),
        .cnt_code_i (cnt_code_i),
        .sig_out    (sig_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input int per, input int code);
        @(posedge clk); #1;
        period_i   = 8'(per);
        cnt_code_i = 3'(code);
        repeat (2) @(posedge clk);
    endtask

    // drive a level and count edges until the output follows
    task automatic measure(input bit v, output int cnt);
        @(posedge clk); #1;
        sig_in = v;
        cnt = 0;
        for (int i = 0; i < 3000; i++) begin
            @(posedge clk); #1;
            cnt++;
            if (sig_out == v) break;
        end
    endtask

    task automatic t_reset;
        check(sig_out == 1'b0, "R7 reset level", int'(sig_out), 0);
    endtask

    // R1 R2 R4: latency for both edge directions
    task automatic t_latency(input int per, input int code);
        int c;
        int exp;
        exp = (code + 3) * per + 2;
        set_cfg(per, code);
        measure(1'b1, c);
        check(c == exp, "R4 rise latency (R1 R2)", c, exp);
        measure(1'b0, c);
        check(c == exp, "R4 fall latency (R1 R2)", c, exp);
    endtask

    // R5: short excursions of both polarities are dropped
    task automatic t_glitch;
        int bad;
        int c;
        set_cfg(4, 1);
        bad = 0;
        @(posedge clk); #1;
        sig_in = 1'b1;
        for (int i = 0; i < 13; i++) begin
            @(posedge clk); #1;
            if (sig_out != 1'b0) bad++;
        end
        sig_in = 1'b0;
        for (int i = 0; i < 30; i++) begin
            @(posedge clk); #1;
            if (sig_out != 1'b0) bad++;
        end
        check(bad == 0, "R5 high pulse rejected", bad, 0);
        measure(1'b1, c);
        check(c == 18, "R5 settle high", c, 18);
        bad = 0;
        sig_in = 1'b0;
        for (int i = 0; i < 13; i++) begin
            @(posedge clk); #1;
            if (sig_out != 1'b1) bad++;
        end
        sig_in = 1'b1;
        for (int i = 0; i < 30; i++) begin
            @(posedge clk); #1;
            if (sig_out != 1'b1) bad++;
        end
        check(bad == 0, "R5 low dip rejected", bad, 0);
        measure(1'b0, c);
        check(c == 18, "R5 settle low", c, 18);
    endtask

    // R6: one-cycle return clears progress
    task automatic t_restart;
        int c;
        set_cfg(4, 1);
        @(posedge clk); #1;
        sig_in = 1'b1;
        repeat (13) @(posedge clk);
        #1 sig_in = 1'b0;
        measure(1'b1, c);
        check(c == 18, "R6 full window after return", c, 18);
        measure(1'b0, c);
    endtask

    // R8: configuration change restarts a pending transition
    task automatic t_cfg_change;
        int c;
        set_cfg(10, 0);
        @(posedge clk); #1;
        sig_in = 1'b1;
        repeat (15) @(posedge clk);
        #1 period_i = 8'd11;
        c = 0;
        for (int i = 0; i < 3000; i++) begin
            @(posedge clk); #1;
            c++;
            if (sig_out == 1'b1) break;
        end
        check(c == 35, "R8 restart after period change", c, 35);
        measure(1'b0, c);
        check(c == 35, "R8 new period in force", c, 35);
    endtask

    // R3: bypass is combinational
    task automatic t_bypass;
        set_cfg(0, 5);
        #1 sig_in = 1'b1;
        #1 check(sig_out == 1'b1, "R3 bypass high", int'(sig_out), 1);
        @(negedge clk);
        sig_in = 1'b0;
        #1 check(sig_out == 1'b0, "R3 bypass low", int'(sig_out), 0);
        @(posedge clk); #1;
        sig_in = 1'b1;
        #1 check(sig_out == 1'b1, "R3 bypass follows at once", int'(sig_out), 1);
        sig_in = 1'b0;
        repeat (2) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latency(1, 0);
        t_latency(3, 2);
        t_latency(5, 7);
        t_latency(2, 4);
        t_latency(255, 7);
        t_glitch();
        t_restart();
        t_cfg_change();
        t_bypass();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            finished = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule